// File: doc/BRIEF.md
# Core Board Control Register Block

This block is the control and status register file of a processor core board. A host reaches it over a simple 32-bit register bus that is addressed by word. It holds the board's clock, memory and init setup words. Writes to these words only land after software has stored an unlock key. The block also drives four board-level lines from one control word: an LED, a remap level, the matching flash-enable, and a one-cycle system reset request.

It also keeps two flag words, each with set and clear access ports, and a small core-local interrupt source. That source is a single software-driven level bit, masked separately for IRQ and FIQ, and it drives the `irq_o` and `fiq_o` lines. A read-only window of 64 words returns the bytes of the memory module's serial-presence-detect table, one byte per word. Byte 31 of that table reports the fitted memory size, which comes from a parameter.

Reads are combinational: `rsp_rdata` is valid in the same cycle that `req_rd` is high, and is zero when no read is requested. An access to a word that does not exist for that direction returns zero and raises `bad_access` for one cycle after the access.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, word 2 (oscillator) reads 0x01000048, word 7 (auxiliary oscillator) reads 0x0007FEFF, word 8 (memory configuration) reads 0x00011122 and word 9 (init) reads 0x00000112. The control word and both flag words read zero, and `flash_en` is 1 while every other output is 0.
- R2: A write to word 5 (key) stores the low 16 bits of the write data. Reading word 5 returns 0x0001A05F when the stored key is 0xA05F, and returns the stored 16-bit value otherwise.
- R3: Writes to words 2, 7, 8 and 9 update the addressed word only while the stored key equals 0xA05F. Otherwise they are ignored and the word keeps its value.
- R4: Word 3 (control) stores write bits 0 and 2 only, and reads back with every other bit zero. `led_o` follows bit 0, `remap_o` follows bit 2, and `flash_en` is the inverse of bit 2.
- R5: A write to word 3 with bit 3 set raises `sys_rst_req` for exactly the cycle after the write. Bit 3 is never stored.
- R6: For the flags word (word 12), a write to word 12 ORs the data in and a write to word 13 clears the bits written as one. Words 14 and 15 do the same for the non-volatile flags word, which reads at word 14.
- R7: The IRQ enable is set at word 18 and cleared at word 19, and reads at word 18. The FIQ enable is set at word 26 and cleared at word 27, and reads at word 26. Word 16 reads the level ANDed with the IRQ enable, and word 24 reads the level ANDed with the FIQ enable.
- R8: A write to word 20 with data bit 0 set makes the soft level bit 1. A write to word 21 with data bit 0 set makes it 0. Words 20, 17 and 25 read the level in bit 0. `irq_o` is high whenever the level and IRQ enable bit 0 are both 1, and `fiq_o` is high whenever the level and FIQ enable bit 0 are both 1.
- R9: A read of word 64+k (k from 0 to 63) returns presence-detect byte k in bits 7:0: byte 0 is 128, byte 1 is 8, byte 9 is 0xA0, and bytes 32 to 63 are 0. Byte 31 is 64, 32, 16, 4 or 2 for a memory size of at least 256, 128, 64 or 32 MB, or less, respectively (default 128 MB gives 32).
- R10: A read of a word with no read meaning, or a write to a word with no write meaning (including words 16, 17, 24, 25 and the presence-detect window), returns zero data and raises `bad_access` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational |
| bad_access | output | 1 | One-cycle pulse after an access to an absent word |
| sys_rst_req | output | 1 | One-cycle system reset request |
| led_o | output | 1 | LED level |
| remap_o | output | 1 | Remap level |
| flash_en | output | 1 | Boot flash visible at address zero |
| irq_o | output | 1 | Core-local IRQ |
| fiq_o | output | 1 | Core-local FIQ |

## Verification
The hardest state to reach is a protected word that was rewritten while unlocked, then locked again and written a second time. Only in that state does an ignored write leave a value different from the reset value. The stimulus unlocks the block, writes a distinctive pattern into the oscillator word, and stores a wrong key. It then writes zero to that word and reads the word back. Key storage is probed the same way, with upper bits set in the write data, so that a read showing the 0xA05F marker proves those upper bits were dropped.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int MEM_MB = 128,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          bad_access,
  output logic          sys_rst_req,
  output logic          led_o,
  output logic          remap_o,
  output logic          flash_en,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [15:0] KEY = 16'hA05F;
  localparam int WIN = 64;
  localparam logic [7:0] SIZE_BYTE = (MEM_MB >= 256) ? 8'd64 :
                                     (MEM_MB >= 128) ? 8'd32 :
                                     (MEM_MB >= 64)  ? 8'd16 :
                                     (MEM_MB >= 32)  ? 8'd4  : 8'd2;

  logic [31:0] osc_q, aux_q, sdr_q, ini_q;
  logic [15:0] key_q;
  logic [1:0]  ctl_q;
  logic [31:0] flg_q, nvf_q, ien_q, fen_q;
  logic        lvl_q;

  wire unlocked = (key_q == KEY);
  wire [31:0] lvl_w = {31'b0, lvl_q};

  function automatic logic [7:0] spd_byte(input int k);
    case (k)
      0: spd_byte = 8'd128;  1: spd_byte = 8'd8;    2: spd_byte = 8'd4;
      3: spd_byte = 8'd11;   4: spd_byte = 8'd9;    5: spd_byte = 8'd1;
      6: spd_byte = 8'd64;   8: spd_byte = 8'd2;    9: spd_byte = 8'hA0;
      10: spd_byte = 8'hA0;  13: spd_byte = 8'd8;   15: spd_byte = 8'd1;
      16: spd_byte = 8'h0E;  17: spd_byte = 8'd4;   18: spd_byte = 8'h1C;
      19: spd_byte = 8'd1;   20: spd_byte = 8'd2;   21: spd_byte = 8'h20;
      22: spd_byte = 8'hC0;  27: spd_byte = 8'h30;  28: spd_byte = 8'h28;
      29: spd_byte = 8'h30;  30: spd_byte = 8'h28;  31: spd_byte = SIZE_BYTE;
      default: spd_byte = 8'd0;
    endcase
  endfunction

  function automatic logic wr_ok(input logic [AW-1:0] a);
    case (int'(a))
      2, 3, 5, 7, 8, 9, 12, 13, 14, 15, 18, 19, 20, 21, 26, 27: wr_ok = 1'b1;
      default: wr_ok = 1'b0;
    endcase
  endfunction

  function automatic logic rd_ok(input logic [AW-1:0] a);
    if (int'(a) >= WIN) rd_ok = 1'b1;
    else case (int'(a))
      2, 3, 5, 7, 8, 9, 12, 14, 16, 17, 18, 20, 24, 25, 26: rd_ok = 1'b1;
      default: rd_ok = 1'b0;
    endcase
  endfunction

  wire wr_go = req_wr && wr_ok(req_addr);
  wire rd_go = req_rd && rd_ok(req_addr);
  wire bad_now = (req_wr && !wr_ok(req_addr)) || (req_rd && !rd_ok(req_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q <= 32'h01000048;
      aux_q <= 32'h0007FEFF;
      sdr_q <= 32'h00011122;
      ini_q <= 32'h00000112;
      key_q <= '0;
      ctl_q <= '0;
      flg_q <= '0;
      nvf_q <= '0;
      ien_q <= '0;
      fen_q <= '0;
      lvl_q <= 1'b0;
      sys_rst_req <= 1'b0;
      bad_access <= 1'b0;
    end else begin
      sys_rst_req <= wr_go && (req_addr == AW'(3)) && req_wdata[3];
      bad_access <= bad_now;
      if (wr_go) begin
        case (int'(req_addr))
          2:  if (unlocked) osc_q <= req_wdata;
          3:  ctl_q <= {req_wdata[2], req_wdata[0]};
          5:  key_q <= req_wdata[15:0];
          7:  if (unlocked) aux_q <= req_wdata;
          8:  if (unlocked) sdr_q <= req_wdata;
          9:  if (unlocked) ini_q <= req_wdata;
          12: flg_q <= flg_q | req_wdata;
          13: flg_q <= flg_q & ~req_wdata;
          14: nvf_q <= nvf_q | req_wdata;
          15: nvf_q <= nvf_q & ~req_wdata;
          18: ien_q <= ien_q | req_wdata;
          19: ien_q <= ien_q & ~req_wdata;
          20: if (req_wdata[0]) lvl_q <= 1'b1;
          21: if (req_wdata[0]) lvl_q <= 1'b0;
          26: fen_q <= fen_q | req_wdata;
          27: fen_q <= fen_q & ~req_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd_go) begin
      if (int'(req_addr) >= WIN) rsp_rdata = {24'b0, spd_byte(int'(req_addr) - WIN)};
      else case (int'(req_addr))
        2:  rsp_rdata = osc_q;
        3:  rsp_rdata = {29'b0, ctl_q[1], 1'b0, ctl_q[0]};
        5:  rsp_rdata = unlocked ? {15'b0, 1'b1, key_q} : {16'b0, key_q};
        7:  rsp_rdata = aux_q;
        8:  rsp_rdata = sdr_q;
        9:  rsp_rdata = ini_q;
        12: rsp_rdata = flg_q;
        14: rsp_rdata = nvf_q;
        16: rsp_rdata = lvl_w & ien_q;
        17, 20, 25: rsp_rdata = lvl_w;
        18: rsp_rdata = ien_q;
        24: rsp_rdata = lvl_w & fen_q;
        26: rsp_rdata = fen_q;
        default: ;
      endcase
    end
  end

  assign led_o    = ctl_q[0];
  assign remap_o  = ctl_q[1];
  assign flash_en = ~ctl_q[1];
  assign irq_o    = lvl_q & ien_q[0];
  assign fiq_o    = lvl_q & fen_q[0];

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == AW'(2) && !unlocked) |=> $stable(osc_q));
  // R5
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == AW'(3) && req_wdata[3]) |=> sys_rst_req);
  // R5
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_wr && req_addr == AW'(3)) |=> !sys_rst_req);
  // R4
  remap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == AW'(3)) |=> (remap_o == $past(req_wdata[2]) && flash_en != remap_o));
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == AW'(19) && req_wdata[0]) |=> !irq_o);
  // R10
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !rd_ok(req_addr)) |=> bad_access);
  // R10
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !rd_ok(req_addr)) |-> rsp_rdata == 32'b0);
endmodule

// File: tb/board_ctl_regs_bench.sv
module board_ctl_regs_bench;
  logic clk = 0, rst_n = 0, req_wr = 0, req_rd = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic bad_access, sys_rst_req, led_o, remap_o, flash_en, irq_o, fiq_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  board_ctl_regs u_board_ctl_regs (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bad_access(bad_access), .sys_rst_req(sys_rst_req), .led_o(led_o),
    .remap_o(remap_o), .flash_en(flash_en), .irq_o(irq_o), .fiq_o(fiq_o));

  // vector: {is_write, requirement number, word, data or expected}
  typedef struct packed { logic w; logic [7:0] req; logic [6:0] a; logic [31:0] d; } vec_t;
  localparam int NV = 40;
  localparam vec_t VT [NV] = '{
    '{1, 2, 5, 32'h0000A05F}, '{0, 2, 5, 32'h0001A05F},       // R2
    '{1, 3, 2, 32'h12345678}, '{0, 3, 2, 32'h12345678},       // R3
    '{1, 2, 5, 32'h00000000}, '{1, 3, 2, 32'h00000000},
    '{0, 3, 2, 32'h12345678}, '{0, 2, 5, 32'h00000000},       // R3 R2
    '{1, 2, 5, 32'hFFFFA05F}, '{0, 2, 5, 32'h0001A05F},       // R2
    '{1, 3, 7, 32'h0000AAAA}, '{0, 3, 7, 32'h0000AAAA},       // R3
    '{1, 2, 5, 32'h00000001}, '{0, 2, 5, 32'h00000001},
    '{1, 3, 8, 32'h00000005}, '{0, 3, 8, 32'h00011122},       // R3
    '{1, 3, 9, 32'h00000007}, '{0, 3, 9, 32'h00000112},
    '{1, 4, 3, 32'hFFFFFFF7}, '{0, 4, 3, 32'h00000005},       // R4
    '{1, 6, 12, 32'h000000F0}, '{1, 6, 12, 32'h0000000F},     // R6
    '{0, 6, 12, 32'h000000FF}, '{1, 6, 13, 32'h0000003C},
    '{0, 6, 12, 32'h000000C3},
    '{1, 6, 14, 32'h00000081}, '{1, 6, 15, 32'h00000001},
    '{0, 6, 14, 32'h00000080},
    '{1, 7, 18, 32'h000000FF}, '{1, 7, 19, 32'h0000000F},     // R7
    '{0, 7, 18, 32'h000000F0},
    '{1, 8, 20, 32'hFFFFFFFF}, '{0, 8, 20, 32'h00000001},     // R8
    '{0, 8, 17, 32'h00000001}, '{0, 7, 16, 32'h00000000},
    '{1, 7, 18, 32'h00000001}, '{0, 7, 16, 32'h00000001},
    '{1, 7, 26, 32'h00000003}, '{0, 7, 26, 32'h00000003},
    '{0, 7, 24, 32'h00000001}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); req_wr = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_wr = 0; req_wdata = '0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); req_rd = 1; req_addr = a;
    #1 d = rsp_rdata;
    @(negedge clk); req_rd = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2, v); check("R1 osc", v, 32'h01000048);
    rd(7, v); check("R1 aux", v, 32'h0007FEFF);
    rd(8, v); check("R1 sdram", v, 32'h00011122);
    rd(9, v); check("R1 init", v, 32'h00000112);
    rd(3, v); check("R1 ctrl", v, 0);
    rd(12, v); check("R1 flags", v, 0);
    rd(14, v); check("R1 nvflags", v, 0);
    check("R1 outputs", {sys_rst_req, led_o, remap_o, flash_en, irq_o, fiq_o, bad_access},
          7'b0001000);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].w) wr(VT[i].a, VT[i].d);
      else begin
        rd(VT[i].a, v);
        check($sformatf("R%0d vector %0d word %0d", VT[i].req, i, VT[i].a), v, VT[i].d);
      end
    end

    // R4 control outputs after 0xFFFFFFF7 write
    check("R4 led/remap/flash", {led_o, remap_o, flash_en}, 3'b110);
    // R8 interrupt lines: level 1, IRQ en bit0 1, FIQ en bit0 1
    check("R8 irq/fiq high", {irq_o, fiq_o}, 2'b11);
    wr(19, 32'h1);
    check("R8 irq cleared", {irq_o, fiq_o}, 2'b01);
    wr(27, 32'h2); rd(26, v); check("R7 fiq enable clear", v, 32'h1);
    wr(21, 32'h1);
    check("R8 soft level cleared", {irq_o, fiq_o}, 2'b00);
    rd(25, v); check("R8 raw fiq level", v, 0);
    rd(24, v); check("R7 fiq status", v, 0);

    // R5 reset request pulse
    @(negedge clk); req_wr = 1; req_addr = 3; req_wdata = 32'h8;
    @(negedge clk); req_wr = 0;
    check("R5 pulse", sys_rst_req, 1);
    @(negedge clk);
    check("R5 pulse ends", sys_rst_req, 0);
    rd(3, v); check("R5 bit3 not stored", v, 0);
    check("R4 remap low", {remap_o, flash_en}, 2'b01);

    // R9 presence-detect window
    rd(64, v); check("R9 byte0", v, 128);
    rd(65, v); check("R9 byte1", v, 8);
    rd(73, v); check("R9 byte9", v, 32'hA0);
    rd(95, v); check("R9 byte31 size", v, 32);
    rd(127, v); check("R9 byte63", v, 0);

    // R10 bad accesses
    @(negedge clk); req_rd = 1; req_addr = 4;
    #1 check("R10 zero data", rsp_rdata, 0);
    @(negedge clk); req_rd = 0;
    check("R10 bad read flag", bad_access, 1);
    @(negedge clk); check("R10 flag one cycle", bad_access, 0);
    wr(16, 32'hFFFF); check("R10 bad write status", bad_access, 1);
    wr(64, 32'hFFFF); check("R10 bad write window", bad_access, 1);
    rd(64, v); check("R10 window unchanged", v, 128);
    rd(16, v); check("R10 status unchanged", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule